// File: doc/BRIEF.md
# I2C Bus Lockup Recovery Sequencer

A master can be reset in the middle of a transfer. When that happens, a slave may be left in the middle of a byte, holding SDA low while it waits for clock edges that never come. The bus then stays stuck. This block frees it.

Recovery starts in one of two ways: on a request, or by itself when SDA has read low for too long while SCL is high and the block is idle. The block then drives the open-drain enables of both lines. It clocks SCL by hand, one pulse at a time, and after each high phase it checks whether SDA has been let go. When SDA reads high, it builds a STOP condition and releases the bus. If SDA is still low after the last allowed pulse, it reports a failure instead.

A separate watchdog watches the SCL input and raises a flag while SCL has been low for longer than a set limit. This catches a slave that stretches the clock without end. The block does not run normal transfers. It sits beside the bus controller and shares the two open-drain pins with it.

Top module: `i2c_bus_unlocker`

## Requirements
- R1: While reset is held and right after it, `scl_oe`, `sda_oe`, `busy`, `done`, `fail` and `stretch_to` are all 0. An enable of 1 pulls the line low, and 0 releases it.
- R2: In idle, a `recover_req` sampled high starts a pulse at the next edge. `busy` goes to 1 and SCL is pulled low for `HALF_CYC` cycles. SCL is then released for the high phase.
- R3: The high phase counts only the cycles in which `scl_in` reads 1. A slave or another device that holds SCL low therefore lengthens the high phase, and a pulse is never shortened.
- R4: At the end of each high phase, `sda_in` is sampled. If it reads 1, a STOP follows in three phases of `HALF_CYC` cycles each:
  - SCL low with SDA released.
  - SCL low with SDA low.
  - SCL released with SDA low.
  After these, both lines are released and `done` pulses for one cycle. SDA is never pulled low unless SCL is already pulled low.
- R5: At most `MAX_PULSES` (default 9) pulses are made. If SDA still reads 0 at the end of the last high phase, `fail` pulses for one cycle. In the same cycle, both lines are released and the block returns to idle.
- R6: `busy` stays at 1 from the first pulse until the cycle in which `done` or `fail` pulses, and it drops in that same cycle. A `recover_req` that arrives while busy has no effect: the number of SCL pulses is the same as without it.
- R7: In idle, once `scl_in`=1 and `sda_in`=0 have been sampled on `STUCK_CYC` consecutive edges, a recovery starts at the next edge with no request. Any edge that breaks the condition restarts the count.
- R8: `stretch_to` is 1 while `scl_in` has read 0 on at least `STRETCH_CYC` consecutive edges. It returns to 0 after the first edge at which `scl_in` reads 1.
- R9: `done` and `fail` are never 1 together. A request made while SDA is already free still produces exactly one pulse, followed by the STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recover_req | input | 1 | Request to start a recovery |
| scl_in | input | 1 | SCL line level, already synchronized |
| sda_in | input | 1 | SDA line level, already synchronized |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Recovery in progress |
| done | output | 1 | One-cycle pulse: bus freed and STOP sent |
| fail | output | 1 | One-cycle pulse: SDA still low after the last pulse |
| stretch_to | output | 1 | SCL has been held low beyond the limit |

## Verification
The bench models a slave that lets go of SDA after a chosen number of falling SCL edges. It uses this to test the edges of the pulse budget:
- Release on the ninth pulse must still end in a STOP. A design that stops one pulse early would report a false failure.
- A slave that never lets go must give exactly nine pulses and then `fail`. A design with an off-by-one counter would clock a tenth time or give up at eight.

Further cases target the timing:
- A request made while the block is busy must not restart the count.
- SCL held low from outside during a high phase must stretch that phase instead of cutting it short.
- A stuck-SDA window broken by a single high cycle must not trigger recovery, where a design that forgets to restart the count would start one too early.
- The stretch flag is sampled on the exact edges where it must rise and fall.

Every cycle, the outputs are compared against a behavioural model. This catches a STOP whose SDA edge comes out of order, which would look like a START to the slave.

// File: rtl/ulk_pkg.sv
package ulk_pkg;

   // Recovery sequencer states; the STOP takes three phases after the last pulse.
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_LOW   = 3'd1,
      ST_HIGH  = 3'd2,
      ST_PRE   = 3'd3,
      ST_SETUP = 3'd4,
      ST_HOLD  = 3'd5
   } ulk_state_e;

   function automatic logic pulls_scl(ulk_state_e s);
      return (s == ST_LOW) || (s == ST_PRE) || (s == ST_SETUP);
   endfunction

   function automatic logic pulls_sda(ulk_state_e s);
      return (s == ST_SETUP) || (s == ST_HOLD);
   endfunction

endpackage

// File: rtl/ulk_phase_timer.sv
module ulk_phase_timer #(
   parameter int HALF_CYC = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic adv,
   output logic last
);
   localparam int TW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
   localparam logic [TW-1:0] LAST_V = TW'(HALF_CYC - 1);

   logic [TW-1:0] cnt;

   assign last = (cnt == LAST_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (clr)    cnt <= '0;
      else if (adv)    cnt <= last ? '0 : cnt + 1'b1;
   end

   // R2: a half period never runs past its length
   a_r2_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST_V);

endmodule

// File: rtl/ulk_stuck_detect.sv
module ulk_stuck_detect #(
   parameter bit AUTO_EN   = 1'b1,
   parameter int STUCK_CYC = 10000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic idle,
   input  logic scl_in,
   input  logic sda_in,
   output logic trig
);
   generate
      if (AUTO_EN) begin : g_auto
         localparam int SW = $clog2(STUCK_CYC + 1);
         localparam logic [SW-1:0] LIM = SW'(STUCK_CYC);
         logic [SW-1:0] run;
         logic          cond;

         assign cond = idle && scl_in && !sda_in;
         assign trig = (run == LIM);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          run <= '0;
            else if (!cond)      run <= '0;
            else if (run != LIM) run <= run + 1'b1;
         end

         // R7: a trigger only follows a sample of the stuck condition
         a_r7_trig_from_stuck: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(trig) |-> $past(idle && scl_in && !sda_in));
      end else begin : g_manual
         assign trig = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/ulk_stretch_wd.sv
module ulk_stretch_wd #(
   parameter int STRETCH_CYC = 3500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   output logic flag
);
   localparam int WW = $clog2(STRETCH_CYC + 1);
   localparam logic [WW-1:0] LIM = WW'(STRETCH_CYC);

   logic [WW-1:0] low_run;

   assign flag = (low_run == LIM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            low_run <= '0;
      else if (scl_in)       low_run <= '0;
      else if (low_run != LIM) low_run <= low_run + 1'b1;
   end

   // R8: a high SCL sample clears the flag on the next cycle
   a_r8_clear_on_high: assert property (@(posedge clk) disable iff (!rst_n)
      scl_in |=> !flag);

endmodule

// File: rtl/ulk_pulse_fsm.sv
module ulk_pulse_fsm
   import ulk_pkg::*;
#(
   parameter int MAX_PULSES = 9
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       scl_in,
   input  logic       sda_in,
   input  logic       ph_last,
   output ulk_state_e state,
   output logic       ph_adv,
   output logic       ph_clr,
   output logic       done,
   output logic       fail
);
   localparam int PW = $clog2(MAX_PULSES + 1);
   localparam logic [PW-1:0] LAST_P = PW'(MAX_PULSES - 1);

   logic [PW-1:0] pcnt;
   logic          step;

   assign ph_clr = (state == ST_IDLE);
   // high phase only advances while the line really reads high
   assign ph_adv = !ph_clr && ((state != ST_HIGH) || scl_in);
   assign step   = ph_adv && ph_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         pcnt  <= '0;
         done  <= 1'b0;
         fail  <= 1'b0;
      end else begin
         done <= 1'b0;
         fail <= 1'b0;
         unique case (state)
            ST_IDLE: if (start) begin
               state <= ST_LOW;
               pcnt  <= '0;
            end
            ST_LOW: if (step) state <= ST_HIGH;
            ST_HIGH: if (step) begin
               pcnt <= pcnt + 1'b1;
               if (sda_in)              state <= ST_PRE;
               else if (pcnt == LAST_P) begin
                  state <= ST_IDLE;
                  fail  <= 1'b1;
               end else                 state <= ST_LOW;
            end
            ST_PRE:   if (step) state <= ST_SETUP;
            ST_SETUP: if (step) state <= ST_HOLD;
            ST_HOLD:  if (step) begin
               state <= ST_IDLE;
               done  <= 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R5: the pulse count never exceeds the budget
   a_r5_pulse_budget: assert property (@(posedge clk) disable iff (!rst_n)
      pcnt <= PW'(MAX_PULSES));

   // R9: completion and failure are exclusive
   a_r9_done_xor_fail: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fail));

   // R6: a completion pulse always leaves the sequencer idle
   a_r6_end_is_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (done || fail) |-> (state == ST_IDLE));

   // R2: an accepted start always enters the low phase
   a_r2_start_to_low: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && start) |=> (state == ST_LOW));

endmodule

// File: rtl/i2c_bus_unlocker.sv
module i2c_bus_unlocker
   import ulk_pkg::*;
#(
   parameter int HALF_CYC    = 500,
   parameter int MAX_PULSES  = 9,
   parameter int STRETCH_CYC = 3500,
   parameter bit AUTO_EN     = 1'b1,
   parameter int STUCK_CYC   = 10000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic recover_req,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_oe,
   output logic sda_oe,
   output logic busy,
   output logic done,
   output logic fail,
   output logic stretch_to
);
   generate
      if (HALF_CYC < 2) begin : g_bad_half
         $error("HALF_CYC must be at least 2");
      end
      if (MAX_PULSES < 1 || MAX_PULSES > 255) begin : g_bad_pulses
         $error("MAX_PULSES must lie in 1..255");
      end
      if (STRETCH_CYC <= 3 * HALF_CYC) begin : g_bad_stretch
         $error("STRETCH_CYC must exceed the longest own SCL low time");
      end
      if (AUTO_EN && STUCK_CYC < 2) begin : g_bad_stuck
         $error("STUCK_CYC must be at least 2");
      end
   endgenerate

   ulk_state_e state;
   logic       ph_adv, ph_clr, ph_last, auto_trig, start;

   assign start = recover_req || auto_trig;

   ulk_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
      .clk (clk), .rst_n (rst_n), .clr (ph_clr), .adv (ph_adv), .last (ph_last)
   );

   ulk_stuck_detect #(.AUTO_EN(AUTO_EN), .STUCK_CYC(STUCK_CYC)) u_stuck (
      .clk (clk), .rst_n (rst_n), .idle (state == ST_IDLE),
      .scl_in (scl_in), .sda_in (sda_in), .trig (auto_trig)
   );

   ulk_pulse_fsm #(.MAX_PULSES(MAX_PULSES)) u_fsm (
      .clk (clk), .rst_n (rst_n), .start (start), .scl_in (scl_in),
      .sda_in (sda_in), .ph_last (ph_last), .state (state),
      .ph_adv (ph_adv), .ph_clr (ph_clr), .done (done), .fail (fail)
   );

   ulk_stretch_wd #(.STRETCH_CYC(STRETCH_CYC)) u_wd (
      .clk (clk), .rst_n (rst_n), .scl_in (scl_in), .flag (stretch_to)
   );

   assign scl_oe = pulls_scl(state);
   assign sda_oe = pulls_sda(state);
   assign busy   = (state != ST_IDLE);

   // R1: nothing is driven on the bus while idle
   a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!scl_oe && !sda_oe));

   // R4: SDA is only taken low beneath a low SCL
   a_r4_sda_under_scl: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> scl_oe);

   // R4: releasing SDA is the STOP edge and coincides with done
   a_r4_stop_edge_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_oe) |-> done);

   // R6: busy only drops alongside a completion pulse
   a_r6_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (done || fail));

endmodule

// File: tb/sim_i2c_bus_unlocker.sv
module sim_i2c_bus_unlocker;
   localparam int HALF    = 4;
   localparam int MAXP    = 9;
   localparam int STRETCH = 20;
   localparam int STUCK   = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic recover_req = 1'b0;
   logic ext_scl_low = 1'b0, ext_sda_low = 1'b0;
   logic slave_en = 1'b0, slave_arm = 1'b0, cnt_clr = 1'b0;
   int   need_falls = 0;
   int   fall_seen = 0;
   int   rises = 0;
   logic prev_scl = 1'b1, scl_oe_d = 1'b0;
   logic scl_oe, sda_oe, busy, done, fail, stretch_to;
   logic scl_in, sda_in, slave_hold;
   int   n_chk = 0, n_fail = 0;

   always #5 clk = ~clk;

   assign slave_hold = slave_en && (fall_seen < need_falls);
   assign scl_in = !scl_oe && !ext_scl_low;
   assign sda_in = !sda_oe && !slave_hold && !ext_sda_low;

   i2c_bus_unlocker #(
      .HALF_CYC(HALF), .MAX_PULSES(MAXP), .STRETCH_CYC(STRETCH),
      .AUTO_EN(1'b1), .STUCK_CYC(STUCK)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .recover_req(recover_req), .scl_in(scl_in),
      .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy),
      .done(done), .fail(fail), .stretch_to(stretch_to)
   );

   // slave model: lets SDA go after a number of falling SCL edges
   always @(posedge clk) begin
      prev_scl <= scl_in;
      scl_oe_d <= scl_oe;
      if (slave_arm) fall_seen <= 0;
      else if (prev_scl && !scl_in) fall_seen <= fall_seen + 1;
      if (cnt_clr) rises <= 0;
      else if (scl_oe && !scl_oe_d) rises <= rises + 1;
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // behavioural reference: 0 idle,1 low,2 high,3 pre,4 setup,5 hold
   int m_st = 0, m_cnt = 0, m_pul = 0, m_stk = 0, m_wd = 0;
   bit m_done = 0, m_fail = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_pul = 0; m_stk = 0; m_wd = 0;
         m_done = 0; m_fail = 0;
      end else begin
         int  nst, ncnt, npul, nstk, nwd;
         bit  trig, adv, fin;
         trig = (m_stk == STUCK);
         nst = m_st; npul = m_pul; ncnt = m_cnt;
         m_done = 0; m_fail = 0;
         adv = (m_st != 0) && (m_st != 2 || scl_in);
         fin = adv && (m_cnt == HALF - 1);
         if (m_st == 0) ncnt = 0;
         else if (adv) ncnt = fin ? 0 : m_cnt + 1;
         if (m_st == 0) begin
            if (recover_req || trig) begin nst = 1; npul = 0; end
         end else if (fin) begin
            if (m_st == 2) begin
               npul = m_pul + 1;
               if (sda_in) nst = 3;
               else if (npul == MAXP) begin nst = 0; m_fail = 1; end
               else nst = 1;
            end else if (m_st == 5) begin nst = 0; m_done = 1; end
            else nst = m_st + 1;
         end
         if (m_st == 0 && scl_in && !sda_in) nstk = (m_stk < STUCK) ? m_stk + 1 : STUCK;
         else nstk = 0;
         if (!scl_in) nwd = (m_wd < STRETCH) ? m_wd + 1 : STRETCH;
         else nwd = 0;
         m_st = nst; m_cnt = ncnt; m_pul = npul; m_stk = nstk; m_wd = nwd;
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         bit e_scl, e_sda;
         e_scl = (m_st == 1) || (m_st == 3) || (m_st == 4);
         e_sda = (m_st == 4) || (m_st == 5);
         chk(scl_oe == e_scl && sda_oe == e_sda && busy == (m_st != 0) &&
             done == m_done && fail == m_fail && stretch_to == (m_wd == STRETCH),
             "R2/R4/R5/R6/R8", "cycle outputs {scl,sda,busy,done,fail,st}",
             {26'd0, scl_oe, sda_oe, busy, done, fail, stretch_to},
             {26'd0, e_scl, e_sda, m_st != 0, m_done, m_fail, m_wd == STRETCH});
      end
   end

   task automatic recover(input int need, input bit exp_done, input int exp_pulses,
                          input int extra_req_at, input int str_at, input int str_len,
                          input string tag);
      int got_done, got_fail;
      @(negedge clk); slave_arm = 1; cnt_clr = 1;
      @(negedge clk); slave_arm = 0; cnt_clr = 0;
      slave_en = 1; need_falls = need; recover_req = 1;
      got_done = 0; got_fail = 0;
      for (int i = 1; i < 2000; i++) begin
         @(negedge clk);
         recover_req = (i == extra_req_at);
         ext_scl_low = (i >= str_at) && (i < str_at + str_len);
         if (done || fail) begin
            got_done = done; got_fail = fail;
            break;
         end
      end
      recover_req = 0; ext_scl_low = 0; slave_en = 0;
      chk(got_done == exp_done && got_fail == !exp_done, tag, "done/fail outcome",
          got_done * 2 + got_fail, exp_done * 2 + !exp_done);
      chk(rises == exp_pulses + (exp_done ? 1 : 0), tag, "SCL low-pull count",
          rises, exp_pulses + (exp_done ? 1 : 0));
      chk(!busy && !scl_oe && !sda_oe, tag, "bus released at end",
          {busy, scl_oe, sda_oe}, 0);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk({scl_oe, sda_oe, busy, done, fail, stretch_to} == 6'd0, "R1", "outputs in reset",
          {scl_oe, sda_oe, busy, done, fail, stretch_to}, 0);
      rst_n = 1;
      @(negedge clk);
      chk({scl_oe, sda_oe, busy, done, fail, stretch_to} == 6'd0, "R1", "outputs after reset",
          {scl_oe, sda_oe, busy, done, fail, stretch_to}, 0);

      recover(3, 1, 3, 0, 0, 0, "R4");          // release after three pulses
      recover(9, 1, 9, 0, 0, 0, "R5");          // release on last allowed pulse
      recover(10, 0, 9, 0, 0, 0, "R5");         // never released: fail
      recover(0, 1, 1, 0, 0, 0, "R9");          // SDA already free
      recover(4, 1, 4, 11, 0, 0, "R6");         // extra request while busy
      recover(2, 1, 2, 0, 1, 6, "R3");          // SCL held during first high phase

      // R7: a single high cycle restarts the stuck count
      for (int i = 0; i < 8; i++) begin ext_sda_low = 1; @(negedge clk); end
      ext_sda_low = 0; @(negedge clk);
      ext_sda_low = 1;
      repeat (8) @(negedge clk);
      chk(busy == 0, "R7", "no start after broken window", busy, 0);
      ext_sda_low = 0;
      repeat (3) @(negedge clk);

      // R7: automatic start after STUCK samples
      slave_arm = 1; @(negedge clk); slave_arm = 0;
      slave_en = 1; need_falls = 2;
      repeat (STUCK) @(negedge clk);
      chk(busy == 0, "R7", "busy before threshold", busy, 0);
      @(negedge clk);
      chk(busy == 1, "R7", "busy at threshold", busy, 1);
      for (int i = 0; i < 500 && !done && !fail; i++) @(negedge clk);
      chk(done == 1, "R7", "auto recovery completes", done, 1);
      slave_en = 0;
      repeat (3) @(negedge clk);

      // R8: stretch watchdog edges
      ext_scl_low = 1;
      repeat (STRETCH - 1) @(negedge clk);
      chk(stretch_to == 0, "R8", "flag one edge early", stretch_to, 0);
      @(negedge clk);
      chk(stretch_to == 1, "R8", "flag at limit", stretch_to, 1);
      repeat (5) @(negedge clk);
      chk(stretch_to == 1 && busy == 0, "R8", "flag held, no recovery", {stretch_to, busy}, 2);
      ext_scl_low = 0;
      @(negedge clk);
      chk(stretch_to == 0, "R8", "flag cleared after high sample", stretch_to, 0);

      repeat (5) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule